// File: doc/BRIEF.md
# Raster Timing Generator

This block turns a pixel clock into the raster timing of a display. Software sets the horizontal and vertical geometry (total length, active length, sync width and the sync-plus-back-porch offset) through a small 32-bit register bus. While running, the block drives horizontal and vertical sync, a data-enable strobe, and the x/y coordinate of the visible pixel. During the visible region it also drives a programmable constant colour.

Two further outputs help the logic around it. A one-clock "kick" pulse fires at a chosen row and column, which is typically used to start the fetch for the next frame. A readable timestamp packs a free-running frame counter together with the current line.

Starting takes effect at once. Stopping waits for the current frame to finish, and a status bit shows when the raster has really halted. Geometry written while the raster runs is held back until the next frame boundary, so no frame mixes two timings.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every output is zero, the status bit reads 0 and the timestamp reads 0.
- R2: Positions are measured from the start of sync. A geometry word holds total minus one in bits 29:16 and the active count, unmodified, in bits 13:0. The horizontal position runs from 0 to total-1, and the vertical position advances each time the horizontal one wraps.
- R3: A sync word holds sync width minus one in bits 13:0, sync-plus-back-porch minus one in bits 29:16 and a sync enable in bit 31. Sync is high while the position is below the width, and it stays low while its enable bit is clear.
- R4: Data-enable is high only when both positions lie in [sbp, sbp+active), where sbp is the stored field plus one. pix_x and pix_y then give the position minus sbp, and they are 0 outside the visible region.
- R5: The kick word holds an enable in bit 31, a row in bits 29:16 and a column in bits 13:0. Kick is high for exactly one clock when the vertical position equals the row and the horizontal position equals the column. Kick writes act at once.
- R6: The colour word holds alpha in bit 30, red in 29:20, green in 19:10 and blue in 9:0. This colour appears on the pixel outputs while data-enable is high, and zeros appear otherwise.
- R7: Outputs are registered. Position (0,0) of a new run appears on the outputs after the second rising edge that follows the edge capturing the start write.
- R8: Writing 1 to bit 0 of the run register starts the raster at once from position (0,0).
- R9: Writing 0 to bit 0 of the run register lets the current frame finish. Status bit 0 stays 1 until the last pixel of that frame; after that, status reads 0 and every output stays low.
- R10: Geometry and sync words written while running take effect from the first pixel of the next frame.
- R11: The timestamp holds the current vertical position in bits 13:0 and a frame counter in bits 31:14. The counter increments at the end of every frame and wraps modulo 2^FRAME_W.
- R12: The register word addresses are: run 0, status 1, horizontal geometry 2, horizontal sync 3, vertical geometry 4, vertical sync 5, kick 6, colour 7, timestamp 8. Read data is registered and valid one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable, visible region |
| kick | output | 1 | One-clock pulse at the programmed row and column |
| pix_x | output | 14 | Visible column index |
| pix_y | output | 14 | Visible row index |
| pix_r | output | 10 | Red channel |
| pix_g | output | 10 | Green channel |
| pix_b | output | 10 | Blue channel |
| pix_a | output | 1 | Alpha bit |

## Verification
The bench builds the block with FRAME_W set to 3 and ADDR_W at its default. With a three-bit frame counter, the timestamp wraps after eight frames, which is within reach of a short run. Programming rasters of only 96 and 60 pixels lets the bench compare every pixel of a geometry change and of a stop request cycle by cycle. It also covers a disabled horizontal sync and the restart from position (0,0).

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int FIELD_W = 14;
  localparam int HI_LSB  = 16;
  localparam int CH_W    = 10;

  localparam int RA_RUN    = 0;
  localparam int RA_STATUS = 1;
  localparam int RA_HGEO   = 2;
  localparam int RA_HSYNC  = 3;
  localparam int RA_VGEO   = 4;
  localparam int RA_VSYNC  = 5;
  localparam int RA_KICK   = 6;
  localparam int RA_COLOUR = 7;
  localparam int RA_STAMP  = 8;

  typedef struct packed {
    logic               sync_en;
    logic [FIELD_W-1:0] tot_m1;
    logic [FIELD_W-1:0] act;
    logic [FIELD_W-1:0] sbp_m1;
    logic [FIELD_W-1:0] sw_m1;
  } axis_cfg_t;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] row;
    logic [FIELD_W-1:0] col;
  } kick_cfg_t;

  typedef struct packed {
    logic            a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } colour_t;

  function automatic axis_cfg_t unpack_axis(input logic [31:0] geo, input logic [31:0] syn);
    axis_cfg_t c;
    c.tot_m1  = geo[HI_LSB +: FIELD_W];
    c.act     = geo[FIELD_W-1:0];
    c.sync_en = syn[31];
    c.sbp_m1  = syn[HI_LSB +: FIELD_W];
    c.sw_m1   = syn[FIELD_W-1:0];
    return c;
  endfunction

  function automatic kick_cfg_t unpack_kick(input logic [31:0] w);
    kick_cfg_t k;
    k.en  = w[31];
    k.row = w[HI_LSB +: FIELD_W];
    k.col = w[FIELD_W-1:0];
    return k;
  endfunction

  function automatic colour_t unpack_colour(input logic [31:0] w);
    colour_t c;
    c.a = w[30];
    c.r = w[29:20];
    c.g = w[19:10];
    c.b = w[9:0];
    return c;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int FRAME_W = 18,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic               running,
  input  logic               frame_end,
  input  logic [FIELD_W-1:0] line,
  input  logic [FRAME_W-1:0] frame_cnt,
  output logic [31:0]        rdata,
  output logic               run_req,
  output axis_cfg_t          hcfg,
  output axis_cfg_t          vcfg,
  output kick_cfg_t          kick_cfg,
  output colour_t            colour
);
  logic [31:0] r_hgeo, r_hsync, r_vgeo, r_vsync, r_kick, r_col;
  logic [31:0] stamp;

  always_comb begin
    stamp = '0;
    stamp[FIELD_W-1:0]       = line;
    stamp[FIELD_W +: FRAME_W] = frame_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_req <= 1'b0;
      r_hgeo  <= '0;
      r_hsync <= '0;
      r_vgeo  <= '0;
      r_vsync <= '0;
      r_kick  <= '0;
      r_col   <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(RA_RUN):    run_req <= wdata[0];
        ADDR_W'(RA_HGEO):   r_hgeo  <= wdata;
        ADDR_W'(RA_HSYNC):  r_hsync <= wdata;
        ADDR_W'(RA_VGEO):   r_vgeo  <= wdata;
        ADDR_W'(RA_VSYNC):  r_vsync <= wdata;
        ADDR_W'(RA_KICK):   r_kick  <= wdata;
        ADDR_W'(RA_COLOUR): r_col   <= wdata;
        default: ;
      endcase
    end
  end

  // Timing shadow: follows the programmed words while idle, frozen within a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      hcfg <= '0;
      vcfg <= '0;
    end else if (!running || frame_end) begin
      hcfg <= unpack_axis(r_hgeo, r_hsync);
      vcfg <= unpack_axis(r_vgeo, r_vsync);
    end
  end

  assign kick_cfg = unpack_kick(r_kick);
  assign colour   = unpack_colour(r_col);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_W'(RA_RUN):    rdata <= {31'b0, run_req};
        ADDR_W'(RA_STATUS): rdata <= {31'b0, running};
        ADDR_W'(RA_HGEO):   rdata <= r_hgeo;
        ADDR_W'(RA_HSYNC):  rdata <= r_hsync;
        ADDR_W'(RA_VGEO):   rdata <= r_vgeo;
        ADDR_W'(RA_VSYNC):  rdata <= r_vsync;
        ADDR_W'(RA_KICK):   rdata <= r_kick;
        ADDR_W'(RA_COLOUR): rdata <= r_col;
        ADDR_W'(RA_STAMP):  rdata <= stamp;
        default:            rdata <= '0;
      endcase
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_end) |=> ($stable(hcfg) && $stable(vcfg))); // R10
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
  import rtg_pkg::*;
#(
  parameter int FRAME_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_req,
  input  axis_cfg_t          hcfg,
  input  axis_cfg_t          vcfg,
  output logic               running,
  output logic [FIELD_W-1:0] hpos,
  output logic [FIELD_W-1:0] vpos,
  output logic               frame_end,
  output logic [FRAME_W-1:0] frame_cnt
);
  logic h_last, v_last;

  assign h_last    = (hpos == hcfg.tot_m1);
  assign v_last    = (vpos == vcfg.tot_m1);
  assign frame_end = running && h_last && v_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      hpos      <= '0;
      vpos      <= '0;
      frame_cnt <= '0;
    end else if (!running) begin
      running <= run_req;
      hpos    <= '0;
      vpos    <= '0;
    end else if (h_last) begin
      hpos <= '0;
      if (v_last) begin
        vpos      <= '0;
        frame_cnt <= frame_cnt + 1'b1;
        running   <= run_req;
      end else begin
        vpos <= vpos + 1'b1;
      end
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> (hpos == '0 && vpos == '0)); // R8
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(frame_end && !run_req)); // R9
  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (hpos <= hcfg.tot_m1)); // R2
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1))); // R11
endmodule

// File: rtl/rtg_pixel_out.sv
module rtg_pixel_out
  import rtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               running,
  input  logic [FIELD_W-1:0] hpos,
  input  logic [FIELD_W-1:0] vpos,
  input  axis_cfg_t          hcfg,
  input  axis_cfg_t          vcfg,
  input  kick_cfg_t          kick_cfg,
  input  colour_t            colour,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               kick,
  output logic [FIELD_W-1:0] pix_x,
  output logic [FIELD_W-1:0] pix_y,
  output colour_t            pix
);
  localparam int AXES = 2;

  axis_cfg_t          cfg     [AXES];
  logic [FIELD_W-1:0] pos     [AXES];
  logic               sync_n  [AXES];
  logic               act_n   [AXES];
  logic [FIELD_W-1:0] coord_n [AXES];
  logic               de_n;

  assign cfg[0] = hcfg;
  assign cfg[1] = vcfg;
  assign pos[0] = hpos;
  assign pos[1] = vpos;

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    logic [FIELD_W:0] start;
    logic [FIELD_W:0] stop;
    assign start      = {1'b0, cfg[g].sbp_m1} + 1'b1;
    assign stop       = start + {1'b0, cfg[g].act};
    assign sync_n[g]  = cfg[g].sync_en && (pos[g] <= cfg[g].sw_m1);
    assign act_n[g]   = ({1'b0, pos[g]} >= start) && ({1'b0, pos[g]} < stop);
    assign coord_n[g] = pos[g] - start[FIELD_W-1:0];
  end

  assign de_n = running && act_n[0] && act_n[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      de    <= 1'b0;
      kick  <= 1'b0;
      pix_x <= '0;
      pix_y <= '0;
      pix   <= '0;
    end else begin
      hsync <= running && sync_n[0];
      vsync <= running && sync_n[1];
      de    <= de_n;
      kick  <= running && kick_cfg.en && (hpos == kick_cfg.col) && (vpos == kick_cfg.row);
      pix_x <= de_n ? coord_n[0] : '0;
      pix_y <= de_n ? coord_n[1] : '0;
      pix   <= de_n ? colour : '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(running) |-> !(hsync || vsync || de || kick)); // R9
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int FRAME_W = 18,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               kick,
  output logic [FIELD_W-1:0] pix_x,
  output logic [FIELD_W-1:0] pix_y,
  output logic [CH_W-1:0]    pix_r,
  output logic [CH_W-1:0]    pix_g,
  output logic [CH_W-1:0]    pix_b,
  output logic               pix_a
);
  logic               run_req, running, frame_end;
  logic [FIELD_W-1:0] hpos, vpos;
  logic [FRAME_W-1:0] frame_cnt;
  axis_cfg_t          hcfg, vcfg;
  kick_cfg_t          kick_cfg;
  colour_t            colour, pix;

  rtg_regs #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .running(running), .frame_end(frame_end), .line(vpos), .frame_cnt(frame_cnt),
    .rdata(reg_rdata), .run_req(run_req), .hcfg(hcfg), .vcfg(vcfg),
    .kick_cfg(kick_cfg), .colour(colour)
  );

  rtg_raster #(.FRAME_W(FRAME_W)) u_raster (
    .clk(clk), .rst(rst), .run_req(run_req), .hcfg(hcfg), .vcfg(vcfg),
    .running(running), .hpos(hpos), .vpos(vpos), .frame_end(frame_end),
    .frame_cnt(frame_cnt)
  );

  rtg_pixel_out u_out (
    .clk(clk), .rst(rst), .running(running), .hpos(hpos), .vpos(vpos),
    .hcfg(hcfg), .vcfg(vcfg), .kick_cfg(kick_cfg), .colour(colour),
    .hsync(hsync), .vsync(vsync), .de(de), .kick(kick),
    .pix_x(pix_x), .pix_y(pix_y), .pix(pix)
  );

  assign pix_a = pix.a;
  assign pix_r = pix.r;
  assign pix_g = pix.g;
  assign pix_b = pix.b;
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int FRAME_W = 3;
  localparam int ADDR_W  = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, de, kick, pix_a;
  logic [13:0] pix_x, pix_y;
  logic [9:0]  pix_r, pix_g, pix_b;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
    .de(de), .kick(kick), .pix_x(pix_x), .pix_y(pix_y), .pix_r(pix_r),
    .pix_g(pix_g), .pix_b(pix_b), .pix_a(pix_a)
  );

  typedef struct {
    int ht, hact, hsw, hsbp, hen;
    int vt, vact, vsw, vsbp, ven;
    int ken, krow, kcol;
  } cfg_t;

  typedef struct packed {
    logic        hs, vs, de, kk;
    logic [13:0] x, y;
    logic [30:0] col;
  } item_t;

  localparam logic [30:0] COLOUR = {1'b1, 10'h3A5, 10'h15A, 10'h2C3};

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    armed  = 0;
  bit    done   = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Driver side: expected items computed from the requirements
  task automatic push_frames(input cfg_t c, input int n);
    for (int f = 0; f < n; f++)
      for (int v = 0; v < c.vt; v++)
        for (int h = 0; h < c.ht; h++) begin
          item_t it;
          bit hin, vin;
          hin   = (h >= c.hsbp) && (h < c.hsbp + c.hact);
          vin   = (v >= c.vsbp) && (v < c.vsbp + c.vact);
          it.hs = (c.hen != 0) && (h < c.hsw);
          it.vs = (c.ven != 0) && (v < c.vsw);
          it.de = hin && vin;
          it.kk = (c.ken != 0) && (h == c.kcol) && (v == c.krow);
          it.x  = it.de ? 14'(h - c.hsbp) : 14'd0;
          it.y  = it.de ? 14'(v - c.vsbp) : 14'd0;
          it.col = it.de ? COLOUR : 31'd0;
          q.push_back(it);
        end
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) q.push_back('0);
  endtask

  // Monitor side
  initial begin
    forever begin
      @(negedge clk);
      if (armed && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        check("R2 R3 R7 R8 sync", {62'd0, hsync, vsync}, {62'd0, e.hs, e.vs});
        check("R4 R10 data-enable", {63'd0, de}, {63'd0, e.de});
        check("R4 coordinates", {36'd0, pix_x, pix_y}, {36'd0, e.x, e.y});
        check("R5 kick", {63'd0, kick}, {63'd0, e.kk});
        check("R6 R9 colour", {33'd0, pix_a, pix_r, pix_g, pix_b}, {33'd0, e.col});
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic write_cfg(input cfg_t c);
    wr(2, 32'(((c.ht - 1) << 16) | c.hact));
    wr(3, 32'((c.hen << 31) | ((c.hsbp - 1) << 16) | (c.hsw - 1)));
    wr(4, 32'(((c.vt - 1) << 16) | c.vact));
    wr(5, 32'((c.ven << 31) | ((c.vsbp - 1) << 16) | (c.vsw - 1)));
    wr(6, 32'((c.ken << 31) | (c.krow << 16) | c.kcol));
  endtask

  task automatic start_and_arm();
    wr(0, 32'd1);
    @(posedge clk);
    @(posedge clk);
    #1 armed = 1;
  endtask

  task automatic wait_left(input int n);
    while (q.size() > n) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    cfg_t ca, cb;
    logic [31:0] v;
    ca = '{ht:12, hact:5, hsw:2, hsbp:4, hen:1, vt:8, vact:4, vsw:1, vsbp:2, ven:1,
           ken:1, krow:5, kcol:3};
    cb = '{ht:10, hact:4, hsw:1, hsbp:3, hen:0, vt:6, vact:3, vsw:2, vsbp:2, ven:1,
           ken:0, krow:1, kcol:1};
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    check("R1 outputs", {46'd0, hsync, vsync, de, kick, pix_x}, 64'd0);
    check("R1 pixel", {33'd0, pix_a, pix_r, pix_g, pix_b}, 64'd0);
    rd(1, v); check("R1 R12 status", {32'd0, v}, 64'd0);
    rd(8, v); check("R1 R11 timestamp", {32'd0, v}, 64'd0);

    // First run: two frames of A, switch to B mid-frame (R10), stop in B (R9)
    write_cfg(ca);
    wr(7, {1'b0, COLOUR});
    push_frames(ca, 2);
    push_frames(cb, 2);
    push_idle(10);
    start_and_arm();
    rd(1, v); check("R8 R12 status while running", {32'd0, v}, 64'd1);
    wait_left(2 * 60 + 10 + 20);
    write_cfg(cb);
    wait_left(10 + 40);
    wr(0, 32'd0);
    rd(1, v); check("R9 status during pending frame", {32'd0, v}, 64'd1);
    wait_left(0);
    armed = 0;
    repeat (3) @(posedge clk);
    rd(1, v); check("R9 status after stop", {32'd0, v}, 64'd0);
    rd(8, v); check("R11 timestamp after four frames", {32'd0, v}, 64'(32'd4 << 14));

    // Second run: restart from origin, line index, frame counter wrap
    push_frames(cb, 5);
    push_idle(5);
    start_and_arm();
    wait_left(161);
    rd(8, v); check("R11 timestamp line index", {32'd0, v}, 64'((32'd6 << 14) | 32'd2));
    wait_left(5 + 30);
    wr(0, 32'd0);
    wait_left(0);
    armed = 0;
    repeat (3) @(posedge clk);
    rd(1, v); check("R9 status after second stop", {32'd0, v}, 64'd0);
    rd(8, v); check("R11 frame counter wrap", {32'd0, v}, 64'(32'd1 << 14));
    check("R9 outputs idle", {46'd0, hsync, vsync, de, kick, pix_x}, 64'd0);

    done = 1;
    finish_up();
  end
endmodule